// File: doc/BRIEF.md
# Dual-Mode Two-Wire Serial EEPROM Slave

This block behaves as the slave side of a two-wire serial EEPROM whose clock and data lines are toggled by software on a host. It samples both lines on the system clock and detects start and stop conditions and clock edges. It then walks a bit-cycle counter that has fixed acknowledge slots. Through this counter it captures addresses, stores written bytes in an internal byte memory and streams read bytes back on a single serial data output.

A static mode input chooses between two protocol variants. In the compact variant there is no device-address byte: the first byte carries a 7-bit word address and a read flag. In the extended variant a device-address byte comes first, and its least significant bit is the read flag. One or two word-address bytes follow it. The block infers how many address bytes there are from the first repeated start it sees after reset. A typical host sets the address with a write, issues a repeated start and then reads sequentially.

Top module: `eeprom2w_slave`

## Requirements
- R1: After reset `sda_o` is 0 and every memory byte reads back as 0x00.
- R2: A start (SDA falling while SCL is high) opens a transaction and restarts the bit count at 0, even in the middle of a byte. The count advances on each SCL rising edge, and SDA is captured on each SCL falling edge.
- R3: Extended mode, two address bytes. The device byte ends in 0, followed by a high and a low address byte. The 13-bit address is formed from the low 13 bits of those 16. Each following data byte is stored at the current address, which then increments and wraps from 0x1FFF to 0x0000. A memory location is chosen by the low `MEM_AW` address bits.
- R4: While the width is undecided, extended mode treats the address as two bytes. The first start that arrives with a bit count of at least 9 decides the width: a count of 28 selects two address bytes, and any other count selects one. The decision holds until reset.
- R5: Extended mode, one address byte. The single address byte is followed by data bytes. The address increments after each stored byte and wraps from 0xFF to 0x00.
- R6: Extended read (device byte ending in 1). In bit cycles 10 to 17, `sda_o` carries bit (17 − cycle) of the byte at the current address, so each byte goes out MSB first. After each byte's acknowledge clock the address increments, masked to the current address width.
- R7: `sda_o` is 0 outside read data cycles: in acknowledge slots, during writes and while no transaction is open.
- R8: Falling edges in acknowledge slots shift nothing. In extended mode these are cycles 9, 18 and 27; in compact mode it is cycle 9. This holds even when SDA is high in those slots.
- R9: Compact mode. Bits 7:1 of the first byte are the word address and bit 0 is the read flag (1 = read). Written bytes are stored at that word and reads stream from it. The word advances by one after each byte, wraps from 127 to 0 and keeps the read flag.
- R10: A stop (SDA rising while SCL is high) closes the transaction. Later SCL and SDA activity changes neither memory nor address until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples both serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_ext | input | 1 | Static protocol select: 1 = extended (device byte), 0 = compact |
| scl_i | input | 1 | Serial clock line from the host |
| sda_i | input | 1 | Serial data line from the host |
| sda_o | output | 1 | Serial read data bit driven back to the host |

## Verification
The hardest behaviour to reach from the ports is the address-width decision. It is taken only once after reset, so the bench needs a fresh reset for each width. It must also attempt a second, differently shaped repeated start to show that the first decision sticks. The stimulus makes that second attempt in two-byte mode: it issues a read whose repeated start lands at cycle 19. A following two-byte write and read must then still land at the intended address. Wrap-around is reached by aiming writes and reads at the top address of each width, 0x1FFF, 0xFF and word 127.

// File: rtl/eep_pkg.sv
package eep_pkg;

    localparam int CYC_W = 6;   // bit-cycle counter width
    localparam int WA_W  = 13;  // widest word address

    localparam logic [CYC_W-1:0] CY_DEV_FIRST = 6'd1;
    localparam logic [CYC_W-1:0] CY_DEV_LAST  = 6'd8;
    localparam logic [CYC_W-1:0] CY_ACK_A     = 6'd9;
    localparam logic [CYC_W-1:0] CY_RD_LO     = 6'd10;
    localparam logic [CYC_W-1:0] CY_RD_HI     = 6'd17;
    localparam logic [CYC_W-1:0] CY_ACK_B     = 6'd18;
    localparam logic [CYC_W-1:0] CY_NAR_LAST  = 6'd26;
    localparam logic [CYC_W-1:0] CY_ACK_C     = 6'd27;
    localparam logic [CYC_W-1:0] CY_DET_WIDE  = 6'd28;
    localparam logic [CYC_W-1:0] CY_WIDE_LAST = 6'd35;
    localparam logic [CYC_W-1:0] CY_WRAP_WIDE = 6'd36;
    localparam logic [CYC_W-1:0] CY_ONE       = 6'd1;
    localparam logic [WA_W-1:0]  ADDR_ONE     = 13'd1;

    typedef struct packed {
        logic scl_c;
        logic scl_p;
        logic sda_c;
        logic sda_p;
    } line_t;

    typedef struct packed {
        logic             started;
        logic             known;
        logic             one_byte;
        logic             dev_rd;
        logic [CYC_W-1:0] cyc;
        logic [WA_W-1:0]  addr;
        logic [6:0]       shreg;
    } eep_state_t;

    // Mask an address to the active width: 8 bits or the full 13.
    function automatic logic [WA_W-1:0] fit_addr(input logic [WA_W-1:0] a, input logic narrow);
        return narrow ? {{(WA_W-8){1'b0}}, a[7:0]} : a;
    endfunction

    // Compact mode: advance the 7-bit word, keep bit 0 (read flag).
    function automatic logic [WA_W-1:0] leg_step(input logic [WA_W-1:0] a);
        logic [7:0] s;
        s = a[7:0] + 8'd2;
        return {{(WA_W-8){1'b0}}, s};
    endfunction

endpackage

// File: rtl/eep_line_sampler.sv
module eep_line_sampler
    import eep_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev,
    output logic sda_lvl
);

    line_t ln_d, ln_q;

    always_comb begin
        ln_d       = ln_q;
        ln_d.scl_p = ln_q.scl_c;
        ln_d.sda_p = ln_q.sda_c;
        ln_d.scl_c = scl_i;
        ln_d.sda_c = sda_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ln_q <= '1;   // idle bus is high on both lines
        else        ln_q <= ln_d;
    end

    assign scl_rise = ln_q.scl_c & ~ln_q.scl_p;
    assign scl_fall = ~ln_q.scl_c & ln_q.scl_p;
    assign start_ev = ln_q.scl_c & ln_q.scl_p & ln_q.sda_p & ~ln_q.sda_c;
    assign stop_ev  = ln_q.scl_c & ln_q.scl_p & ~ln_q.sda_p & ln_q.sda_c;
    assign sda_lvl  = ln_q.sda_c;

endmodule

// File: rtl/eep_byte_mem.sv
module eep_byte_mem #(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    localparam int DEPTH = 1 << AW;

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/eeprom2w_slave.sv
module eeprom2w_slave
    import eep_pkg::*;
#(
    parameter int MEM_AW = 9   // memory holds 2**MEM_AW bytes, 7..13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_ext,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o
);

    logic scl_rise, scl_fall, start_ev, stop_ev, sda_lvl;

    eep_line_sampler u_lines (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .sda_lvl  (sda_lvl)
    );

    eep_state_t st_d, st_q;

    logic              mem_we;
    logic [MEM_AW-1:0] mem_idx;
    logic [7:0]        mem_rdata;
    logic [7:0]        byte_in;
    logic [CYC_W-1:0]  cyc_inc;
    logic              is_ack, dev_phase, data_phase, last_bit, rd_flag;

    eep_byte_mem #(.AW(MEM_AW)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (mem_idx),
        .wdata (byte_in),
        .raddr (mem_idx),
        .rdata (mem_rdata)
    );

    // Decode of the current bit cycle
    always_comb begin
        mem_idx    = mode_ext ? st_q.addr[MEM_AW-1:0] : MEM_AW'(st_q.addr[7:1]);
        rd_flag    = mode_ext ? st_q.dev_rd : st_q.addr[0];
        is_ack     = (st_q.cyc == CY_ACK_A) ||
                     (mode_ext && (st_q.cyc == CY_ACK_B || st_q.cyc == CY_ACK_C));
        dev_phase  = (st_q.cyc >= CY_DEV_FIRST) && (st_q.cyc <= CY_DEV_LAST);
        data_phase = !mode_ext || (st_q.one_byte ? (st_q.cyc > CY_ACK_B) : (st_q.cyc > CY_ACK_C));
        last_bit   = mode_ext ? (st_q.one_byte ? (st_q.cyc == CY_NAR_LAST) : (st_q.cyc == CY_WIDE_LAST))
                              : (st_q.cyc == CY_RD_HI);
        byte_in    = {st_q.shreg, sda_lvl};
        cyc_inc    = st_q.cyc + CY_ONE;
    end

    // Next-state logic
    always_comb begin
        st_d   = st_q;
        mem_we = 1'b0;
        if (start_ev) begin
            if (!st_q.known && st_q.cyc >= CY_ACK_A) begin
                st_d.known    = 1'b1;
                st_d.one_byte = (st_q.cyc != CY_DET_WIDE);
            end
            st_d.cyc     = '0;
            st_d.started = 1'b1;
        end else if (stop_ev) begin
            st_d.started = 1'b0;
        end else if (st_q.started && scl_rise) begin
            st_d.cyc = cyc_inc;
            if (mode_ext) begin
                if (st_q.dev_rd && cyc_inc == CY_ACK_B) begin
                    st_d.cyc  = CY_ACK_A;
                    st_d.addr = fit_addr(st_q.addr + ADDR_ONE, st_q.one_byte);
                end else if (st_q.one_byte && cyc_inc == CY_ACK_C) begin
                    st_d.cyc = CY_ACK_B;
                end else if (cyc_inc == CY_WRAP_WIDE) begin
                    st_d.cyc = CY_ACK_C;
                end
            end else if (cyc_inc == CY_ACK_B) begin
                st_d.cyc = CY_ACK_A;
                if (st_q.addr[0]) st_d.addr = leg_step(st_q.addr);
            end
        end else if (st_q.started && scl_fall && !is_ack) begin
            if (dev_phase) begin
                if (mode_ext) st_d.dev_rd = sda_lvl;
                else          st_d.addr   = {{(WA_W-8){1'b0}}, st_q.addr[6:0], sda_lvl};
            end else if (st_q.cyc > CY_ACK_A && !rd_flag) begin
                if (data_phase) begin
                    st_d.shreg = byte_in[6:0];
                    if (last_bit) begin
                        mem_we    = 1'b1;
                        st_d.addr = mode_ext ? fit_addr(st_q.addr + ADDR_ONE, st_q.one_byte)
                                             : leg_step(st_q.addr);
                    end
                end else begin
                    st_d.addr = fit_addr({st_q.addr[WA_W-2:0], sda_lvl}, st_q.one_byte);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Serial read output: MSB of the byte in cycle 10, LSB in cycle 17
    always_comb begin
        sda_o = st_q.started && rd_flag &&
                (st_q.cyc >= CY_RD_LO) && (st_q.cyc <= CY_RD_HI) &&
                mem_rdata[3'(CY_RD_HI - st_q.cyc)];
    end

    // R2: a start leaves an open transaction at bit cycle zero
    a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (st_q.started && st_q.cyc == '0));

    // R2: the wraps keep the counter below the wide wrap point
    a_r2_cyc_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cyc < CY_WRAP_WIDE);

    // R4: once decided, the address width never changes
    a_r4_width_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.known |=> (st_q.known && $stable(st_q.one_byte)));

    // R8: acknowledge-slot falling edges move no address or flag state
    a_r8_ack_no_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.started && scl_fall && mode_ext &&
         (st_q.cyc == CY_ACK_A || st_q.cyc == CY_ACK_B || st_q.cyc == CY_ACK_C))
        |=> ($stable(st_q.addr) && $stable(st_q.dev_rd)));

    // R10: with no open transaction, address and count stay frozen
    a_r10_idle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.started && !start_ev) |=> ($stable(st_q.addr) && $stable(st_q.cyc)));

endmodule

// File: tb/tb_eeprom2w_slave.sv
module tb_eeprom2w_slave;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_ext = 1'b1;
    logic scl = 1'b1;
    logic sda = 1'b1;
    logic sda_o;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    eeprom2w_slave #(.MEM_AW(9)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_ext (mode_ext),
        .scl_i    (scl),
        .sda_i    (sda),
        .sda_o    (sda_o)
    );

    // {13-bit address, data} for two-byte extended write/read pairs
    localparam logic [20:0] VEC [6] = '{
        21'h0003A5, 21'h00FF5C, 21'h01003C,
        21'h01ABE7, 21'h123481, 21'h1FFF42
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic do_reset(input logic ext);
        @(negedge clk);
        mode_ext = ext; scl = 1'b1; sda = 1'b1; rst_n = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        settle();
    endtask

    task automatic put_bit(input logic b);
        sda = b;    settle();
        scl = 1'b1; settle();
        scl = 1'b0; settle();
    endtask

    task automatic get_bit(output logic b);
        sda = 1'b1; settle();
        scl = 1'b1; settle();
        b = sda_o;
        scl = 1'b0; settle();
    endtask

    task automatic do_start();
        sda = 1'b1; settle();
        scl = 1'b1; settle();
        sda = 1'b0; settle();
        scl = 1'b0; settle();
    endtask

    task automatic do_stop();
        sda = 1'b0; settle();
        scl = 1'b1; settle();
        sda = 1'b1; settle();
    endtask

    // Eight bits MSB first, then an acknowledge clock with SDA left high
    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        put_bit(1'b1);
    endtask

    task automatic recv_byte(output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        sda = 1'b0; settle();
        scl = 1'b1; settle();
        chk("R7 ack slot quiet", {15'd0, sda_o}, 16'd0);
        scl = 1'b0; settle();
    endtask

    task automatic ext_wbegin(input logic wide, input logic [12:0] a);
        do_start();
        send_byte(8'hA0);
        if (wide) send_byte({3'b000, a[12:8]});
        send_byte(a[7:0]);
    endtask

    task automatic ext_point(input logic wide, input logic [12:0] a);
        ext_wbegin(wide, a);
        do_start();
        send_byte(8'hA1);
    endtask

    task automatic expect_byte(input string tag, input logic [7:0] exp);
        logic [7:0] got;
        recv_byte(got);
        chk(tag, {8'd0, got}, {8'd0, exp});
    endtask

    initial begin
        logic [7:0] junk;

        // ---------------- Phase A: extended, two-byte width ----------------
        do_reset(1'b1);
        chk("R1 sda_o after reset", {15'd0, sda_o}, 16'd0);

        // Repeated start at cycle 28 decides two address bytes (R4)
        ext_point(1'b1, 13'h0005);
        expect_byte("R1 memory zero", 8'h00);
        expect_byte("R1 memory zero next", 8'h00);
        do_stop();
        chk("R7 idle after stop", {15'd0, sda_o}, 16'd0);

        // Table of single-byte writes, each read back (R3, R8 via high acks)
        for (int i = 0; i < 6; i++) begin
            ext_wbegin(1'b1, VEC[i][20:8]);
            send_byte(VEC[i][7:0]);
            do_stop();
            ext_point(1'b1, VEC[i][20:8]);
            expect_byte("R3 R8 table readback", VEC[i][7:0]);
            do_stop();
        end

        // Multi-byte write across 0x1FFF -> 0x0000 and sequential read (R3, R6)
        ext_wbegin(1'b1, 13'h1FFE);
        send_byte(8'h11);
        send_byte(8'h22);
        send_byte(8'h33);
        do_stop();
        ext_point(1'b1, 13'h1FFE);
        expect_byte("R6 seq read 0x1FFE", 8'h11);
        expect_byte("R6 seq read 0x1FFF", 8'h22);
        expect_byte("R3 wrap to 0x0000", 8'h33);
        do_stop();

        // Activity without a start must not write (R10)
        for (int i = 7; i >= 0; i--) put_bit(i[0]);
        for (int i = 0; i < 16; i++) put_bit(1'b0);
        for (int i = 7; i >= 0; i--) put_bit(8'h99 >> i);
        chk("R10 sda_o idle", {15'd0, sda_o}, 16'd0);
        ext_point(1'b1, 13'h0000);
        expect_byte("R10 memory untouched", 8'h33);
        do_stop();

        // One-byte-shaped repeated start (cycle 19) must not re-decide (R4)
        do_start();
        send_byte(8'hA0);
        send_byte(8'h40);
        do_start();
        send_byte(8'hA1);
        recv_byte(junk);
        do_stop();
        ext_wbegin(1'b1, 13'h0040);
        send_byte(8'h5D);
        do_stop();
        ext_point(1'b1, 13'h0040);
        expect_byte("R4 width stays two bytes", 8'h5D);
        do_stop();

        // Start in mid-byte restarts the count (R2)
        do_start();
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
        ext_wbegin(1'b1, 13'h0020);
        send_byte(8'h6E);
        do_stop();
        ext_point(1'b1, 13'h0020);
        expect_byte("R2 restart mid-byte", 8'h6E);
        do_stop();

        // ---------------- Phase B: extended, one-byte width ----------------
        do_reset(1'b1);
        ext_point(1'b0, 13'h0010);   // repeated start at cycle 19 -> one byte
        expect_byte("R4 one-byte detect read", 8'h00);
        do_stop();
        ext_wbegin(1'b0, 13'h0010);
        send_byte(8'hAA);
        send_byte(8'hBB);
        do_stop();
        ext_point(1'b0, 13'h0010);
        expect_byte("R5 write 0x10", 8'hAA);
        expect_byte("R5 write 0x11", 8'hBB);
        do_stop();
        ext_wbegin(1'b0, 13'h00FF);
        send_byte(8'hCC);
        send_byte(8'hDD);
        do_stop();
        ext_point(1'b0, 13'h00FF);
        expect_byte("R5 write 0xFF", 8'hCC);
        expect_byte("R6 read wraps to 0x00", 8'hDD);
        do_stop();
        ext_point(1'b0, 13'h0000);
        expect_byte("R5 write wrapped to 0x00", 8'hDD);
        expect_byte("R6 next byte 0x01", 8'h00);
        do_stop();

        // ---------------- Phase C: compact mode ----------------
        do_reset(1'b0);
        do_start();
        send_byte({7'h05, 1'b0});
        send_byte(8'h5A);
        send_byte(8'h6B);
        do_stop();
        do_start();
        send_byte({7'h05, 1'b1});
        expect_byte("R9 read word 5", 8'h5A);
        expect_byte("R9 read word 6", 8'h6B);
        do_stop();
        do_start();
        send_byte({7'h7F, 1'b0});
        send_byte(8'h77);
        send_byte(8'h88);
        do_stop();
        do_start();
        send_byte({7'h7F, 1'b1});
        expect_byte("R9 read word 127", 8'h77);
        expect_byte("R9 read wraps to word 0", 8'h88);
        do_stop();
        do_start();
        send_byte({7'h00, 1'b1});
        expect_byte("R9 write wrapped to word 0", 8'h88);
        expect_byte("R8 compact word 1", 8'h00);
        do_stop();
        chk("R7 compact idle", {15'd0, sda_o}, 16'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule